// File: doc/BRIEF.md
# Multicycle Processor Core

This block is a 32-bit processor core that runs each instruction as a series of short clock steps. The number of steps depends on the instruction class. It executes register-to-register arithmetic, word loads, word stores, branch-on-equal and unconditional jumps. One ALU computes the next program counter, branch targets, load and store addresses and arithmetic results, each in a different step. One word-addressed memory array holds both the program and its data. Holding registers sit behind the memory (instruction and read data), behind the register file (two operands) and behind the ALU (result), so that each step can use what the step before it produced.

A sequencer walks through the steps and sets the operand selects, the PC source select and the write enables. The program counter is updated in two ways: unconditionally, or only when the ALU reports a zero result during a branch compare. A load port writes memory words while the core is held in reset, and a peek port reads any memory word combinationally, so a caller can install a program and then inspect the results it stored. The core pulses `instr_done` during the last step of every instruction.

Top module: `mcyc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the PC to 0, clears all registers and sends the sequencer to the fetch step. While reset is held, `pc` reads 0 and `instr_done` is low.
- R2: Instruction fields are: opcode [31:26], source register [25:21], second register [20:16], destination register [15:11], function code [5:0], and a 16-bit immediate [15:0] that is sign-extended. A jump carries its target in [25:0]. The opcodes are: 0x00 register-to-register, 0x23 load, 0x2B store, 0x04 branch-on-equal, 0x02 jump.
- R3: A register-to-register instruction writes the destination register with the result selected by its function code: 0x20 add, 0x22 subtract, 0x24 bitwise and, 0x25 bitwise or, 0x2A signed less-than (1 or 0).
- R4: A load writes the second register with the memory word at byte address (source register + sign-extended immediate). The word index is the byte address shifted right by 2.
- R5: A store writes the second register's value to the memory word at byte address (source register + sign-extended immediate).
- R6: A branch-on-equal moves the PC to PC+4+(sign-extended immediate shifted left by 2) when both registers are equal, and to PC+4 otherwise. The PC changes only in a step that requests an unconditional write, or a conditional write while the ALU result is zero.
- R7: A jump sets the PC to {upper 4 bits of PC+4, target field, 2'b00}.
- R8: Register 0 always reads as zero, and writes to it are ignored.
- R9: Step counts per instruction: register-to-register 4, load 5, store 4, branch 3, jump 3. `instr_done` is high during the final step of each instruction, the step after it is a fetch, and each fetch advances the PC by 4.
- R10: The instruction register loads only in the fetch step and holds its value for the remaining steps of the instruction.
- R11: No step both writes memory and fetches an instruction, and no step writes both memory and the register file.
- R12: When `load_en` is high, the `load_data` word is written to memory word `load_word` at the next clock edge. `peek_data` always shows memory word `peek_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Memory load strobe, used while in reset |
| load_word | input | MEM_AW | Word index for the load port |
| load_data | input | 32 | Word to load |
| peek_word | input | MEM_AW | Word index for the peek port |
| peek_data | output | 32 | Memory word at `peek_word` |
| pc | output | 32 | Current program counter |
| instr_done | output | 1 | High in the final step of an instruction |

## Verification
The program reads two operands, takes their difference in both directions, and runs every function code on them. This includes a less-than where one side is negative, so a signed compare can be told apart from an unsigned one. Two branches are run back to back, one with unequal registers and one with equal registers. An instruction placed after the taken branch, and one placed after the jump, would leave nonzero values if they ran, so this separates a correct target calculation from falling through. Writes to register 0 and a store of register 0 over a word that was preloaded nonzero show that register 0 stays zero. The scoreboard checks the step count of every instruction in program order, which tells apart the five step sequences.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
    localparam int XLEN = 32;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_ADDR, ST_LDRD, ST_LDWB,
        ST_STWR, ST_EXEC, ST_RWB, ST_BRANCH, ST_JUMP
    } step_e;

    typedef enum logic [1:0] {
        ALU_ADD, ALU_SUB, ALU_FUNCT
    } alu_mode_e;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_J     = 6'h02;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef struct packed {
        logic       addr_sel_alu;  // memory address from ALU result holder
        logic       instr_latch;   // load instruction register
        logic       opa_sel;       // ALU first operand: 0 PC, 1 operand A
        logic [1:0] opb_sel;       // 0 B, 1 four, 2 imm, 3 imm<<2
        alu_mode_e  alu_mode;
        logic [1:0] pc_sel;        // 0 ALU, 1 held result, 2 jump target
        logic       pc_upd;
        logic       pc_upd_eq;
        logic       mem_we;
        logic       rf_we;
        logic       dst_sel_rd;
        logic       wb_sel_mem;
        logic       done;
    } ctrl_t;
endpackage

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
    import mcyc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] opcode,
    output step_e      step,
    output ctrl_t      ctl
);
    step_e step_d, step_q;

    always_comb begin
        ctl    = '0;
        step_d = step_q;
        case (step_q)
            ST_FETCH: begin
                ctl.instr_latch = 1'b1;
                ctl.opb_sel     = 2'd1;
                ctl.pc_upd      = 1'b1;
                step_d          = ST_DECODE;
            end
            ST_DECODE: begin
                ctl.opb_sel = 2'd3;
                case (opcode)
                    OP_LW, OP_SW: step_d = ST_ADDR;
                    OP_RTYPE:     step_d = ST_EXEC;
                    OP_BEQ:       step_d = ST_BRANCH;
                    OP_J:         step_d = ST_JUMP;
                    default: begin
                        ctl.done = 1'b1;
                        step_d   = ST_FETCH;
                    end
                endcase
            end
            ST_ADDR: begin
                ctl.opa_sel = 1'b1;
                ctl.opb_sel = 2'd2;
                step_d      = (opcode == OP_LW) ? ST_LDRD : ST_STWR;
            end
            ST_LDRD: begin
                ctl.addr_sel_alu = 1'b1;
                step_d           = ST_LDWB;
            end
            ST_LDWB: begin
                ctl.rf_we      = 1'b1;
                ctl.wb_sel_mem = 1'b1;
                ctl.done       = 1'b1;
                step_d         = ST_FETCH;
            end
            ST_STWR: begin
                ctl.addr_sel_alu = 1'b1;
                ctl.mem_we       = 1'b1;
                ctl.done         = 1'b1;
                step_d           = ST_FETCH;
            end
            ST_EXEC: begin
                ctl.opa_sel  = 1'b1;
                ctl.alu_mode = ALU_FUNCT;
                step_d       = ST_RWB;
            end
            ST_RWB: begin
                ctl.rf_we      = 1'b1;
                ctl.dst_sel_rd = 1'b1;
                ctl.done       = 1'b1;
                step_d         = ST_FETCH;
            end
            ST_BRANCH: begin
                ctl.opa_sel   = 1'b1;
                ctl.alu_mode  = ALU_SUB;
                ctl.pc_sel    = 2'd1;
                ctl.pc_upd_eq = 1'b1;
                ctl.done      = 1'b1;
                step_d        = ST_FETCH;
            end
            ST_JUMP: begin
                ctl.pc_sel = 2'd2;
                ctl.pc_upd = 1'b1;
                ctl.done   = 1'b1;
                step_d     = ST_FETCH;
            end
            default: step_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= ST_FETCH;
        else     step_q <= step_d;
    end

    assign step = step_q;
endmodule

// File: rtl/mcyc_alu.sv
module mcyc_alu
    import mcyc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_mode_e    mode,
    input  logic [5:0]   funct,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        y = a + b;
        case (mode)
            ALU_SUB: y = a - b;
            ALU_FUNCT: begin
                case (funct)
                    FN_SUB: y = a - b;
                    FN_AND: y = a & b;
                    FN_OR:  y = a | b;
                    FN_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
                    default: y = a + b;
                endcase
            end
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/mcyc_regfile.sv
module mcyc_regfile #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata
);
    logic [W-1:0] rf_d [DEPTH];
    logic [W-1:0] rf_q [DEPTH];

    always_comb begin
        rf_d = rf_q;
        if (we && (waddr != '0)) rf_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) rf_q[i] <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rdata_a = (raddr_a == '0) ? '0 : rf_q[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : rf_q[raddr_b];
endmodule

// File: rtl/mcyc_mem.sv
module mcyc_mem #(
    parameter int W     = 32,
    parameter int WORDS = 256,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata,
    input  logic [AW-1:0] peek_addr,
    output logic [W-1:0]  peek_data
);
    logic [W-1:0] mem_d [WORDS];
    logic [W-1:0] mem_q [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rdata     = mem_q[raddr];
    assign peek_data = mem_q[peek_addr];
endmodule

// File: rtl/mcyc_core.sv
module mcyc_core
    import mcyc_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    localparam int MEM_AW   = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [MEM_AW-1:0] load_word,
    input  logic [XLEN-1:0]   load_data,
    input  logic [MEM_AW-1:0] peek_word,
    output logic [XLEN-1:0]   peek_data,
    output logic [XLEN-1:0]   pc,
    output logic              instr_done
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] mem_hold;
        logic [XLEN-1:0] opa;
        logic [XLEN-1:0] opb;
        logic [XLEN-1:0] alu_hold;
    } dp_t;

    dp_t dp_d, dp_q;
    step_e step;
    ctrl_t ctl;

    logic [XLEN-1:0] pc_q, ir_q, opa_q, opb_q, alu_hold_q, mem_hold_q;
    logic [XLEN-1:0] ext_imm, alu_a, alu_b, alu_y, pc_next, jump_tgt;
    logic [XLEN-1:0] mem_rdata, rf_a, rf_b, rf_wdata;
    logic [MEM_AW-1:0] mem_word;
    logic [4:0] rf_waddr;
    logic alu_zero, pc_load;

    assign pc_q       = dp_q.pc;
    assign ir_q       = dp_q.ir;
    assign opa_q      = dp_q.opa;
    assign opb_q      = dp_q.opb;
    assign alu_hold_q = dp_q.alu_hold;
    assign mem_hold_q = dp_q.mem_hold;

    mcyc_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .opcode (ir_q[31:26]),
        .step   (step),
        .ctl    (ctl)
    );

    assign ext_imm = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
    assign alu_a   = ctl.opa_sel ? opa_q : pc_q;

    always_comb begin
        case (ctl.opb_sel)
            2'd0:    alu_b = opb_q;
            2'd1:    alu_b = 32'd4;
            2'd2:    alu_b = ext_imm;
            default: alu_b = {ext_imm[XLEN-3:0], 2'b00};
        endcase
    end

    mcyc_alu #(.W(XLEN)) u_alu (
        .a     (alu_a),
        .b     (alu_b),
        .mode  (ctl.alu_mode),
        .funct (ir_q[5:0]),
        .y     (alu_y),
        .zero  (alu_zero)
    );

    assign jump_tgt = {pc_q[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};

    always_comb begin
        case (ctl.pc_sel)
            2'd0:    pc_next = alu_y;
            2'd1:    pc_next = alu_hold_q;
            default: pc_next = jump_tgt;
        endcase
    end

    assign pc_load = ctl.pc_upd | (ctl.pc_upd_eq & alu_zero);

    assign mem_word = ctl.addr_sel_alu ? alu_hold_q[MEM_AW+1:2] : pc_q[MEM_AW+1:2];

    mcyc_mem #(.W(XLEN), .WORDS(MEM_WORDS)) u_mem (
        .clk       (clk),
        .we        (load_en | ctl.mem_we),
        .waddr     (load_en ? load_word : mem_word),
        .wdata     (load_en ? load_data : opb_q),
        .raddr     (mem_word),
        .rdata     (mem_rdata),
        .peek_addr (peek_word),
        .peek_data (peek_data)
    );

    assign rf_waddr = ctl.dst_sel_rd ? ir_q[15:11] : ir_q[20:16];
    assign rf_wdata = ctl.wb_sel_mem ? mem_hold_q : alu_hold_q;

    mcyc_regfile #(.W(XLEN), .DEPTH(32)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .raddr_a (ir_q[25:21]),
        .raddr_b (ir_q[20:16]),
        .rdata_a (rf_a),
        .rdata_b (rf_b),
        .we      (ctl.rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata)
    );

    always_comb begin
        dp_d          = dp_q;
        dp_d.pc       = pc_load ? pc_next : pc_q;
        dp_d.ir       = ctl.instr_latch ? mem_rdata : ir_q;
        dp_d.mem_hold = mem_rdata;
        dp_d.opa      = rf_a;
        dp_d.opb      = rf_b;
        dp_d.alu_hold = alu_y;
    end

    always_ff @(posedge clk) begin
        if (rst) dp_q <= '0;
        else     dp_q <= dp_d;
    end

    assign pc         = pc_q;
    assign instr_done = ctl.done;
endmodule

// File: rtl/mcyc_core_chk.sv
module mcyc_core_chk
    import mcyc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input ctrl_t       ctl,
    input step_e       step,
    input logic        alu_zero,
    input logic [31:0] ir_q,
    input logic [31:0] pc_q,
    input logic [31:0] opa_q
);
    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctl.instr_latch |=> $stable(ir_q)); // R10

    AST_MEM_WRITE_ALONE: assert property (@(posedge clk) disable iff (rst)
        ctl.mem_we |-> (!ctl.instr_latch && !ctl.rf_we)); // R11

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(ctl.pc_upd || (ctl.pc_upd_eq && alu_zero)) |=> $stable(pc_q)); // R6

    AST_DONE_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
        ctl.done |=> (step == ST_FETCH)); // R9

    AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (step == ST_FETCH) |=> (pc_q == $past(pc_q) + 32'd4)); // R9

    AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
        (ir_q[25:21] == 5'd0) |=> (opa_q == 32'd0)); // R8
endmodule

bind mcyc_core mcyc_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .step     (step),
    .alu_zero (alu_zero),
    .ir_q     (ir_q),
    .pc_q     (pc_q),
    .opa_q    (opa_q)
);

// File: tb/mcyc_core_tb.sv
module mcyc_core_tb;
    localparam int MW = 256;
    localparam int AW = $clog2(MW);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_en = 1'b0;
    logic [AW-1:0] load_word = '0;
    logic [31:0]   load_data = '0;
    logic [AW-1:0] peek_word = '0;
    logic [31:0]   peek_data;
    logic [31:0]   pc;
    logic          instr_done;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    string tag_q[$];
    int cyc = 0;
    logic [31:0] prog [30];

    always #5 clk = ~clk;

    mcyc_core #(.MEM_WORDS(MW)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .load_en    (load_en),
        .load_word  (load_word),
        .load_data  (load_data),
        .peek_word  (peek_word),
        .peek_data  (peek_data),
        .pc         (pc),
        .instr_done (instr_done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [31:0] rr(input int rs, input int rt, input int rd, input logic [5:0] fn);
        rr = {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] ii(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        ii = {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] jj(input int tgt);
        jj = {6'h02, 26'(tgt)};
    endfunction

    task automatic load(input int w, input logic [31:0] d);
        @(negedge clk);
        load_en   = 1'b1;
        load_word = AW'(w);
        load_data = d;
    endtask

    task automatic peek(input int w, input logic [31:0] expv, input string req);
        @(negedge clk);
        peek_word = AW'(w);
        #1;
        chk(peek_data === expv, req, longint'(peek_data), longint'(expv));
    endtask

    // scoreboard driver: expected step count of each instruction in order
    task automatic expect_instr(input int n, input string tag);
        exp_q.push_back(n);
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst) begin
            cyc = 0;
        end else begin
            cyc++;
            if (instr_done) begin
                if (exp_q.size() > 0) begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(cyc == e, t, cyc, e);
                end
                cyc = 0;
            end
        end
    end

    initial begin
        int wd;
        prog[0]  = ii(6'h23, 0, 1, 16'h0100);   // r1 = 7
        prog[1]  = ii(6'h23, 0, 2, 16'h0104);   // r2 = 5
        prog[2]  = rr(1, 2, 3, 6'h20);          // add  -> 12
        prog[3]  = rr(1, 2, 4, 6'h22);          // sub  -> 2
        prog[4]  = rr(1, 2, 5, 6'h24);          // and  -> 5
        prog[5]  = rr(1, 2, 6, 6'h25);          // or   -> 7
        prog[6]  = rr(2, 1, 7, 6'h2A);          // slt 5<7 -> 1
        prog[7]  = rr(1, 2, 8, 6'h2A);          // slt 7<5 -> 0
        prog[8]  = rr(2, 1, 9, 6'h22);          // -2
        prog[9]  = rr(9, 2, 10, 6'h2A);         // signed -2<5 -> 1
        prog[10] = rr(1, 1, 0, 6'h20);          // write to r0 ignored
        prog[11] = ii(6'h04, 1, 2, 16'h0005);   // not taken
        prog[12] = ii(6'h04, 6, 1, 16'h0001);   // taken to word 14
        prog[13] = rr(1, 1, 11, 6'h20);         // skipped
        prog[14] = jj(16);
        prog[15] = rr(1, 1, 12, 6'h20);         // skipped
        prog[16] = ii(6'h2B, 0, 3, 16'h0108);
        prog[17] = ii(6'h2B, 0, 4, 16'h010C);
        prog[18] = ii(6'h2B, 0, 5, 16'h0110);
        prog[19] = ii(6'h2B, 0, 6, 16'h0114);
        prog[20] = ii(6'h2B, 0, 7, 16'h0118);
        prog[21] = ii(6'h2B, 0, 8, 16'h011C);
        prog[22] = ii(6'h2B, 0, 9, 16'h0120);
        prog[23] = ii(6'h2B, 0, 10, 16'h0124);
        prog[24] = ii(6'h2B, 0, 0, 16'h0128);
        prog[25] = ii(6'h2B, 0, 11, 16'h012C);
        prog[26] = ii(6'h2B, 0, 12, 16'h0130);
        prog[27] = ii(6'h23, 0, 13, 16'h0108);
        prog[28] = ii(6'h2B, 0, 13, 16'h0134);
        prog[29] = jj(29);

        repeat (2) @(posedge clk);
        for (int i = 0; i < 30; i++) load(i, prog[i]);
        load(64, 32'd7);
        load(65, 32'd5);
        for (int i = 74; i <= 76; i++) load(i, 32'hDEAD_BEEF);
        @(negedge clk);
        load_en = 1'b0;

        @(negedge clk);
        chk(pc == 32'd0, "R1 pc in reset", longint'(pc), 0);
        chk(instr_done == 1'b0, "R1 done in reset", longint'(instr_done), 0);
        peek(64, 32'd7, "R12 load/peek");
        peek(1, prog[1], "R12 load/peek program");

        expect_instr(5, "R9 R4 lw");
        expect_instr(5, "R9 R4 lw");
        for (int i = 0; i < 9; i++) expect_instr(4, "R9 R3 rtype");
        expect_instr(3, "R9 R6 beq not taken");
        expect_instr(3, "R9 R6 beq taken");
        expect_instr(3, "R9 R7 j");
        for (int i = 0; i < 11; i++) expect_instr(4, "R9 R5 sw");
        expect_instr(5, "R9 R4 lw");
        expect_instr(4, "R9 R5 sw");
        expect_instr(3, "R9 R7 j loop");

        @(negedge clk);
        rst = 1'b0;

        wd = 0;
        while (exp_q.size() > 0 && wd < 5000) begin
            @(negedge clk);
            wd++;
        end
        chk(wd < 5000, "R9 watchdog", wd, 5000);

        peek(66, 32'd12, "R3 R2 R10 add");
        peek(67, 32'd2, "R3 sub");
        peek(68, 32'd5, "R3 and");
        peek(69, 32'd7, "R3 or");
        peek(70, 32'd1, "R3 slt true");
        peek(71, 32'd0, "R3 slt false");
        peek(72, 32'hFFFF_FFFE, "R3 sub negative");
        peek(73, 32'd1, "R3 signed slt");
        peek(74, 32'd0, "R8 r0 stays zero");
        peek(75, 32'd0, "R6 taken branch skip");
        peek(76, 32'd0, "R7 jump skip");
        peek(77, 32'd12, "R4 R5 R11 lw after sw");
        peek(64, 32'd7, "R5 R11 data intact");
        peek(65, 32'd5, "R5 R11 data intact");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule